// File: doc/BRIEF.md
# Audio Codec Control Write Sequencer

This block owns the control port of an external audio codec. It never toggles the two-wire bus itself. Instead it hands bytes, one at a time, to a byte-level two-wire master over a valid/ready handshake, and it waits for that master's per-byte acknowledge result. Every codec register write is a 16-bit word. The register index sits in the top seven bits and a nine-bit value in the low nine. The high byte goes out first, marked as the start of a transaction, and the low byte follows, marked as the stop and last byte.

When reset is released the block configures the codec on its own, with a fixed seven-write sequence. After that it takes one command at a time over a valid/ready port. The commands are:
- a line-input volume in percent;
- a headphone volume in percent;
- whole-device power on or off;
- power on or off for a mask of sub-blocks.

Each command becomes one or two register writes. A missing acknowledge does not stop the sequence. It is latched in a sticky error flag, together with the register index of the first write that failed.

Top module: `codec_ctl_seq`

## Requirements
- R1: Each write is a 16-bit word {register index[6:0], value[8:0]}. It is sent as two bytes: the high byte first with start=1, stop=0, last=0, then the low byte with start=0, stop=1, last=1.
- R2: A byte offered on the byte port keeps its data and flags until it is taken (valid and ready both high). The next byte is offered only after the acknowledge result of the previous byte has been returned.
- R3: The device address output during a write equals the `dev_addr` input as sampled when that write began.
- R4: After reset the block writes, in this order: register 15 with 0; register 5 with DIG_CFG; register 4 with ANA_CFG; register 7 with FMT_CFG; register 8 with SMP_CFG; register 9 with 1; register 6 with 0x040.
- R5: Headphone volume (op 1) uses code = (min(pct,100)*7+50)/100. It writes register 3 and then register 2, each with value 0x180 | code (bit 7 enables zero-cross, bit 8 loads both channels).
- R6: Line-input volume (op 0) with pct 0 writes 0x180 (mute plus load-both) to register 1 and then to register 0.
- R7: Line-input volume (op 0) with nonzero pct uses code = (min(pct,100)*15+50)/100. It writes 0x100 | code (mute clear) to register 1 and then to register 0.
- R8: Power-on (op 2) writes 0x07F to register 6. Power-off (op 3) writes 0x080 to register 6.
- R9: Sub-block power (mask = arg[6:0]). Op 4 (on) writes ~mask & 0x7F to register 6. Op 5 (off) writes the mask itself to register 6.
- R10: A not-acknowledged byte sets `ack_err`, which stays set until reset. `err_reg` holds the register index of the first failing write. The remaining writes are still sent.
- R11: `cmd_ready` is high only when the init sequence has finished and no write is pending. A command offered earlier is held, not lost, and runs once ready rises. `done` pulses once at the end of init and once per accepted command.
- R12: Ops 6 and 7 are accepted, produce no byte and still pulse `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_addr | input | 8 | Codec write address, pre-shifted (typically 0x36) |
| cmd_valid | input | 1 | Command offered |
| cmd_op | input | 3 | Command code (0 line vol, 1 headphone vol, 2 power on, 3 power off, 4 blocks on, 5 blocks off) |
| cmd_arg | input | 8 | Percent volume or sub-block mask |
| cmd_ready | output | 1 | Command accepted this cycle when valid |
| busy | output | 1 | Init or a command is in progress |
| done | output | 1 | One-cycle pulse when init or a command completes |
| ack_err | output | 1 | Sticky not-acknowledged flag |
| err_reg | output | 7 | Register index of the first failing write |
| bm_addr | output | 8 | Device address for the byte master |
| bm_valid | output | 1 | Byte offered to the byte master |
| bm_data | output | 8 | Byte value |
| bm_start | output | 1 | Byte opens a transaction |
| bm_stop | output | 1 | Stop follows this byte |
| bm_last | output | 1 | Final byte of the transaction |
| bm_ready | input | 1 | Byte master takes the byte |
| bm_ack_valid | input | 1 | Acknowledge result for the last byte taken |
| bm_nack | input | 1 | Result was not-acknowledged |

## Verification
The assertions assume that the byte master returns exactly one acknowledge pulse per accepted byte. That pulse must come only after the byte was taken, and never while a byte is still being offered. They also assume that `cmd_op` and `cmd_arg` hold steady while `cmd_valid` waits. The bench model of the byte master follows these rules. It records a transfer only when it raises `bm_ready` against a valid byte, and it schedules a single acknowledge zero to two cycles after that. It also randomises the ready gaps, and it keeps each command stable from the moment it is offered until the cycle after acceptance.

// File: rtl/codec_ctl_pkg.sv
package codec_ctl_pkg;
  localparam int IDX_W  = 7;
  localparam int VAL_W  = 9;
  localparam int WORD_W = IDX_W + VAL_W;
  localparam int INIT_LEN = 7;

  typedef logic [WORD_W-1:0] ctl_word_t;

  localparam logic [IDX_W-1:0] RG_LIN_L = 7'd0;
  localparam logic [IDX_W-1:0] RG_LIN_R = 7'd1;
  localparam logic [IDX_W-1:0] RG_HP_L  = 7'd2;
  localparam logic [IDX_W-1:0] RG_HP_R  = 7'd3;
  localparam logic [IDX_W-1:0] RG_ANA   = 7'd4;
  localparam logic [IDX_W-1:0] RG_DIG   = 7'd5;
  localparam logic [IDX_W-1:0] RG_PWR   = 7'd6;
  localparam logic [IDX_W-1:0] RG_FMT   = 7'd7;
  localparam logic [IDX_W-1:0] RG_SMP   = 7'd8;
  localparam logic [IDX_W-1:0] RG_ACT   = 7'd9;
  localparam logic [IDX_W-1:0] RG_RST   = 7'd15;

  localparam logic [2:0] OP_LINE_VOL = 3'd0;
  localparam logic [2:0] OP_HP_VOL   = 3'd1;
  localparam logic [2:0] OP_PWR_ON   = 3'd2;
  localparam logic [2:0] OP_PWR_OFF  = 3'd3;
  localparam logic [2:0] OP_BLK_ON   = 3'd4;
  localparam logic [2:0] OP_BLK_OFF  = 3'd5;

  // rounded percent-to-code scaling, percent clamped at 100
  function automatic logic [3:0] pct_scale(input logic [7:0] pct, input logic [3:0] full);
    logic [11:0] p;
    logic [11:0] num;
    p   = (pct > 8'd100) ? 12'd100 : {4'd0, pct};
    num = p * {8'd0, full} + 12'd50;
    return 4'(num / 12'd100);
  endfunction
endpackage

// File: rtl/codec_init_rom.sv
module codec_init_rom
  import codec_ctl_pkg::*;
#(
  parameter logic [VAL_W-1:0] DIG_CFG = 9'h006,
  parameter logic [VAL_W-1:0] ANA_CFG = 9'h012,
  parameter logic [VAL_W-1:0] FMT_CFG = 9'h00A,
  parameter logic [VAL_W-1:0] SMP_CFG = 9'h000
) (
  input  logic [2:0] idx,
  output ctl_word_t  word
);
  always_comb begin
    case (idx)
      3'd0:    word = {RG_RST, 9'h000};
      3'd1:    word = {RG_DIG, DIG_CFG};
      3'd2:    word = {RG_ANA, ANA_CFG};
      3'd3:    word = {RG_FMT, FMT_CFG};
      3'd4:    word = {RG_SMP, SMP_CFG};
      3'd5:    word = {RG_ACT, 9'h001};
      3'd6:    word = {RG_PWR, 9'h040};
      default: word = '0;
    endcase
  end
endmodule

// File: rtl/codec_cmd_encoder.sv
module codec_cmd_encoder
  import codec_ctl_pkg::*;
(
  input  logic [2:0] op,
  input  logic [7:0] arg,
  output ctl_word_t  word0,
  output ctl_word_t  word1,
  output logic [1:0] nwords
);
  logic [3:0]       line_code;
  logic [3:0]       hp_full;
  logic [VAL_W-1:0] line_val;
  logic [VAL_W-1:0] hp_val;

  always_comb begin
    line_code = pct_scale(arg, 4'd15);
    hp_full   = pct_scale(arg, 4'd7);
    line_val  = (arg == 8'd0) ? 9'h180 : {5'b1_0000, line_code};
    hp_val    = {2'b11, 4'b0000, hp_full[2:0]};
  end

  always_comb begin
    word0  = '0;
    word1  = '0;
    nwords = 2'd0;
    case (op)
      OP_LINE_VOL: begin word0 = {RG_LIN_R, line_val}; word1 = {RG_LIN_L, line_val}; nwords = 2'd2; end
      OP_HP_VOL:   begin word0 = {RG_HP_R, hp_val};    word1 = {RG_HP_L, hp_val};    nwords = 2'd2; end
      OP_PWR_ON:   begin word0 = {RG_PWR, 9'h07F}; nwords = 2'd1; end
      OP_PWR_OFF:  begin word0 = {RG_PWR, 9'h080}; nwords = 2'd1; end
      OP_BLK_ON:   begin word0 = {RG_PWR, 2'b00, ~arg[6:0]}; nwords = 2'd1; end
      OP_BLK_OFF:  begin word0 = {RG_PWR, 2'b00, arg[6:0]};  nwords = 2'd1; end
      default:     nwords = 2'd0;
    endcase
  end
endmodule

// File: rtl/codec_word_tx.sv
module codec_word_tx
  import codec_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  ctl_word_t        word,
  input  logic [7:0]       addr,
  output logic             tx_busy,
  output logic             fin,
  output logic             fin_nack,
  output logic [IDX_W-1:0] fin_reg,
  output logic [7:0]       bm_addr,
  output logic             bm_valid,
  output logic [7:0]       bm_data,
  output logic             bm_start,
  output logic             bm_stop,
  output logic             bm_last,
  input  logic             bm_ready,
  input  logic             bm_ack_valid,
  input  logic             bm_nack
);
  typedef enum logic [2:0] {TX_IDLE, TX_HI, TX_HACK, TX_LO, TX_LACK} tx_st_e;
  tx_st_e    st;
  ctl_word_t word_q;
  logic      nack_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= TX_IDLE;
      word_q   <= '0;
      bm_addr  <= '0;
      nack_q   <= 1'b0;
      fin      <= 1'b0;
      fin_nack <= 1'b0;
    end else begin
      fin <= 1'b0;
      case (st)
        TX_IDLE: if (go) begin
          word_q  <= word;
          bm_addr <= addr;
          nack_q  <= 1'b0;
          st      <= TX_HI;
        end
        TX_HI:   if (bm_ready) st <= TX_HACK;
        TX_HACK: if (bm_ack_valid) begin
          nack_q <= bm_nack;
          st     <= TX_LO;
        end
        TX_LO:   if (bm_ready) st <= TX_LACK;
        TX_LACK: if (bm_ack_valid) begin
          fin      <= 1'b1;
          fin_nack <= nack_q | bm_nack;
          st       <= TX_IDLE;
        end
        default: st <= TX_IDLE;
      endcase
    end
  end

  assign tx_busy  = (st != TX_IDLE);
  assign bm_valid = (st == TX_HI) || (st == TX_LO);
  assign bm_start = (st == TX_HI);
  assign bm_stop  = (st == TX_LO);
  assign bm_last  = (st == TX_LO);
  assign bm_data  = (st == TX_HI) ? word_q[WORD_W-1:8] : word_q[7:0];
  assign fin_reg  = word_q[WORD_W-1:VAL_W];

  // R2: offered byte is held until taken
  p_hold_byte_r2: assert property (@(posedge clk) disable iff (rst)
    bm_valid && !bm_ready |=> bm_valid && $stable(bm_data) && $stable(bm_start));

  // R2: after a byte is taken, no byte is offered until its acknowledge
  p_wait_ack_r2: assert property (@(posedge clk) disable iff (rst)
    bm_valid && bm_ready |=> !bm_valid);

  // R1: stop byte always follows a start byte of the same word
  p_stop_after_start_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(bm_stop) |-> $past(st == TX_HACK));

  // R2: acknowledge only arrives while a byte result is awaited (input rule)
  p_ack_expected_r2: assert property (@(posedge clk) disable iff (rst)
    bm_ack_valid |-> (st == TX_HACK) || (st == TX_LACK));
endmodule

// File: rtl/codec_ctl_seq.sv
module codec_ctl_seq
  import codec_ctl_pkg::*;
#(
  parameter logic [8:0] DIG_CFG = 9'h006,
  parameter logic [8:0] ANA_CFG = 9'h012,
  parameter logic [8:0] FMT_CFG = 9'h00A,
  parameter logic [8:0] SMP_CFG = 9'h000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] dev_addr,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_op,
  input  logic [7:0] cmd_arg,
  output logic       cmd_ready,
  output logic       busy,
  output logic       done,
  output logic       ack_err,
  output logic [6:0] err_reg,
  output logic [7:0] bm_addr,
  output logic       bm_valid,
  output logic [7:0] bm_data,
  output logic       bm_start,
  output logic       bm_stop,
  output logic       bm_last,
  input  logic       bm_ready,
  input  logic       bm_ack_valid,
  input  logic       bm_nack
);
  localparam logic [2:0] INIT_LAST = 3'(INIT_LEN - 1);

  typedef enum logic [1:0] {T_IDLE, T_SEND, T_WAIT} top_st_e;
  top_st_e    st;
  logic       in_init;
  logic [2:0] idx;
  logic [1:0] n_q;
  ctl_word_t  cw_q [2];

  ctl_word_t        init_word, enc_w0, enc_w1, send_word;
  logic [1:0]       enc_n;
  logic             go, tx_busy, fin, fin_nack, last_word;
  logic [IDX_W-1:0] fin_reg;

  codec_init_rom #(.DIG_CFG(DIG_CFG), .ANA_CFG(ANA_CFG), .FMT_CFG(FMT_CFG), .SMP_CFG(SMP_CFG))
    u_rom (.idx(idx), .word(init_word));

  codec_cmd_encoder u_enc (.op(cmd_op), .arg(cmd_arg), .word0(enc_w0), .word1(enc_w1), .nwords(enc_n));

  assign go        = (st == T_SEND);
  assign send_word = in_init ? init_word : cw_q[idx[0]];
  assign last_word = in_init ? (idx == INIT_LAST) : (idx == 3'(n_q) - 3'd1);

  codec_word_tx u_tx (
    .clk(clk), .rst(rst), .go(go), .word(send_word), .addr(dev_addr),
    .tx_busy(tx_busy), .fin(fin), .fin_nack(fin_nack), .fin_reg(fin_reg),
    .bm_addr(bm_addr), .bm_valid(bm_valid), .bm_data(bm_data),
    .bm_start(bm_start), .bm_stop(bm_stop), .bm_last(bm_last),
    .bm_ready(bm_ready), .bm_ack_valid(bm_ack_valid), .bm_nack(bm_nack));

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= T_SEND;
      in_init <= 1'b1;
      idx     <= '0;
      n_q     <= '0;
      cw_q[0] <= '0;
      cw_q[1] <= '0;
      done    <= 1'b0;
      ack_err <= 1'b0;
      err_reg <= '0;
    end else begin
      done <= 1'b0;
      if (fin && fin_nack && !ack_err) begin
        ack_err <= 1'b1;
        err_reg <= fin_reg;
      end
      case (st)
        T_IDLE: if (cmd_valid) begin
          cw_q[0] <= enc_w0;
          cw_q[1] <= enc_w1;
          n_q     <= enc_n;
          idx     <= '0;
          if (enc_n == 2'd0) done <= 1'b1;
          else               st   <= T_SEND;
        end
        T_SEND: st <= T_WAIT;
        T_WAIT: if (fin) begin
          if (last_word) begin
            st      <= T_IDLE;
            in_init <= 1'b0;
            done    <= 1'b1;
          end else begin
            idx <= idx + 3'd1;
            st  <= T_SEND;
          end
        end
        default: st <= T_IDLE;
      endcase
    end
  end

  assign cmd_ready = (st == T_IDLE);
  assign busy      = (st != T_IDLE);

  // R11: no command is taken while init is still running
  p_no_cmd_in_init_r11: assert property (@(posedge clk) disable iff (rst)
    in_init |-> !cmd_ready);

  // R2: a new word is launched only into an idle byte sender
  p_go_idle_r2: assert property (@(posedge clk) disable iff (rst)
    go |-> !tx_busy);

  // R10: error flag and failing index stay once set
  p_sticky_err_r10: assert property (@(posedge clk) disable iff (rst)
    ack_err |=> ack_err && $stable(err_reg));

  // R11: completion is reported only after a finished word or an empty command
  p_done_cause_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(fin) || $past(cmd_valid && cmd_ready));
endmodule

// File: tb/test_codec_ctl_seq.sv
`timescale 1ns/1ps
module test_codec_ctl_seq;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] dev_addr = 8'h36;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [7:0] cmd_arg = '0;
  logic       cmd_ready, busy, done, ack_err;
  logic [6:0] err_reg;
  logic [7:0] bm_addr, bm_data;
  logic       bm_valid, bm_start, bm_stop, bm_last;
  logic       bm_ready = 1'b0, bm_ack_valid = 1'b0, bm_nack = 1'b0;

  codec_ctl_seq i_codec_ctl_seq (.*);

  always #2 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int done_cnt = 0, done_exp = 0;
  logic [15:0] got_q[$];
  logic [15:0] exp_q[$];
  logic [7:0]  exp_addr = 8'h36;
  logic [7:0]  hi_b;
  bit          nack_mode = 1'b0;
  bit          ack_pend = 1'b0;
  int          ack_dly = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic int scl(input int v, input int m);
    int p = (v > 100) ? 100 : v;
    return (p * m + 50) / 100;
  endfunction

  function automatic logic [15:0] mk(input int r, input int d);
    return 16'(((r & 8'h7F) << 9) | (d & 9'h1FF));
  endfunction

  task automatic expect_cmd(input int op, input int arg);
    int d;
    case (op)
      0: begin
        d = (arg == 0) ? 'h180 : ('h100 | scl(arg, 15));
        exp_q.push_back(mk(1, d)); exp_q.push_back(mk(0, d));
      end
      1: begin
        d = 'h180 | scl(arg, 7);
        exp_q.push_back(mk(3, d)); exp_q.push_back(mk(2, d));
      end
      2: exp_q.push_back(mk(6, 'h07F));
      3: exp_q.push_back(mk(6, 'h080));
      4: exp_q.push_back(mk(6, (~arg) & 'h7F));
      5: exp_q.push_back(mk(6, arg & 'h7F));
      default: ;
    endcase
  endtask

  // byte master model and byte monitor
  always @(negedge clk) begin
    if (done) done_cnt++;
    bm_ack_valid = 1'b0;
    bm_nack = 1'b0;
    if (ack_pend) begin
      if (ack_dly == 0) begin
        bm_ack_valid = 1'b1; bm_nack = nack_mode; ack_pend = 1'b0;
      end else ack_dly--;
    end
    bm_ready = rst ? 1'b0 : (($urandom % 4) != 0);
    if (bm_valid && bm_ready) begin
      if (bm_start) begin
        hi_b = bm_data;
        chk(!bm_stop && !bm_last, "R1 first byte flags", {bm_stop, bm_last}, 0);
        chk(bm_addr == exp_addr, "R3 device address", bm_addr, exp_addr);
      end else begin
        chk(bm_stop && bm_last, "R1 second byte flags", {bm_stop, bm_last}, 3);
        got_q.push_back({hi_b, bm_data});
      end
      ack_pend = 1'b1;
      ack_dly = $urandom % 3;
    end
  end

  task automatic drain(input string req);
    chk(got_q.size() == exp_q.size(), {req, " write count"}, got_q.size(), exp_q.size());
    while (got_q.size() > 0 && exp_q.size() > 0) begin
      logic [15:0] g = got_q.pop_front();
      logic [15:0] e = exp_q.pop_front();
      chk(g == e, req, g, e);
    end
    got_q.delete();
    exp_q.delete();
  endtask

  task automatic run_cmd(input int op, input int arg, input string req);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'(op); cmd_arg = 8'(arg);
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    expect_cmd(op, arg);
    done_exp++;
    while (!cmd_ready) @(negedge clk);
    repeat (2) @(negedge clk);
    drain(req);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog R11 actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    void'($urandom(32'd11));
    repeat (3) @(negedge clk);
    // reset state
    chk(!cmd_ready && !bm_valid && !done && !ack_err, "R11 reset state",
        {cmd_ready, bm_valid, done, ack_err}, 0);
    @(negedge clk); rst = 1'b0;
    // init words, with a held-off command offered during init
    exp_q.push_back(mk(15, 0));
    exp_q.push_back(mk(5, 'h006));
    exp_q.push_back(mk(4, 'h012));
    exp_q.push_back(mk(7, 'h00A));
    exp_q.push_back(mk(8, 'h000));
    exp_q.push_back(mk(9, 1));
    exp_q.push_back(mk(6, 'h040));
    done_exp++;
    @(negedge clk);
    chk(!cmd_ready && busy, "R11 not ready during init", cmd_ready, 0);
    run_cmd(1, 50, "R4 R11 init then held headphone command");
    chk(!ack_err, "R10 no error after clean run", ack_err, 0);

    run_cmd(1, 100, "R5 headphone full");
    run_cmd(1, 0, "R5 headphone zero");
    run_cmd(1, 14, "R5 headphone rounding");
    run_cmd(0, 0, "R6 line mute");
    run_cmd(0, 100, "R7 line full");
    run_cmd(0, 3, "R7 line rounds to zero unmuted");
    run_cmd(0, 200, "R7 line clamp");
    run_cmd(2, 0, "R8 power on");
    run_cmd(3, 0, "R8 power off");
    run_cmd(4, 'h41, "R9 blocks on");
    run_cmd(5, 'hC5, "R9 blocks off");
    run_cmd(6, 9, "R12 unused op");
    run_cmd(7, 0, "R12 unused op 7");

    exp_addr = 8'h34; dev_addr = 8'h34;
    run_cmd(2, 0, "R3 changed address");
    exp_addr = 8'h36; dev_addr = 8'h36;

    nack_mode = 1'b1;
    run_cmd(1, 30, "R10 writes continue after nack");
    nack_mode = 1'b0;
    chk(ack_err && err_reg == 7'd3, "R10 error index", {ack_err, err_reg}, {1'b1, 7'd3});
    run_cmd(0, 60, "R10 later clean command");
    chk(ack_err && err_reg == 7'd3, "R10 sticky error", {ack_err, err_reg}, {1'b1, 7'd3});

    for (int i = 0; i < 60; i++) begin
      int op = $urandom % 8;
      int arg = $urandom % 256;
      run_cmd(op, arg, "R1 R5 R7 R9 random command");
    end

    chk(done_cnt == done_exp, "R11 done pulse count", done_cnt, done_exp);
    finish_run();
  end
endmodule